// File: doc/BRIEF.md
# DRAM Device-Side Strobe Cycle Decoder

A clocked behavioural stand-in for the control logic inside an asynchronous, multiplexed-address DRAM. It is meant for benches that check a memory controller. The strobes (row strobe, column strobe, write enable and output enable, all active low) and the address bus are oversampled on a fast clock. The block finds their edges and sorts each bus cycle into a class. It latches row and column addresses from the shared address bus, keeps the internal refresh row counter and decides when the data pins would be driven.

A small array holds data for the low bits of the row and column addresses, so that the controller's reads and writes can be checked end to end. A sequence-error pulse marks strobe orderings that no legal cycle produces. Every output is registered, so each reaction shows one clock after the clock edge that sampled its cause.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After a synchronous reset, `dout_oe` is 0, `cyc_class` is 0 (standby), `rfsh_row_ctr` is 0 and `seq_err` is 0.
- R2: A row-strobe falling edge sampled with the column strobe high latches `addr` into `row_addr` and sets `cyc_class` to 6 (row-only refresh of that row) until a column access follows. `dout_oe` stays 0 and the refresh counter does not move.
- R3: A row-strobe falling edge sampled while the column strobe is already low (and was not falling in the same sample) starts a counter-driven refresh. `cyc_class` becomes 7, `row_addr` takes the counter value from before the step, `addr` is ignored and `dout_oe` is 0.
- R4: One clock after a sample in which both row and column strobes are high, `dout_oe` is 0, and a strobe rising edge that leaves both high sets `cyc_class` to 0.
- R5: With `we_n` high, a read starts at whichever of the column-strobe or `oe_n` falling edges comes later. One clock after that sample, `dout_oe` is 1, `dout` holds the stored word and `cyc_class` is 1. A column fall with `oe_n` high leaves `dout_oe` at 0.
- R6: The refresh counter (`rfsh_row_ctr`) adds one for each counter-driven or hidden refresh, wraps from 2047 to 0 with the default 11-bit width, and holds otherwise. It also holds when both strobes fall in the same sample.
- R7: `we_n` low at a column fall is an early write. It stores `din` at the word indexed by the low 3 row bits and the low 3 column bits, sets `cyc_class` to 2 and leaves `dout_oe` at 0. A `we_n` fall after a read in the same column access is read-modify-write: it stores `din` and sets `cyc_class` to 3.
- R8: A second or later column fall while the row strobe stays low latches a new `col_addr` in the open row and sets `cyc_class` to 4 (page access).
- R9: A column-strobe rise with the row strobe low changes neither `dout` nor `dout_oe`. An `oe_n` rising edge sets `dout_oe` to 0 one clock later.
- R10: After a read, a row-strobe rise and fall with the column strobe held low is a hidden refresh. `cyc_class` becomes 5, the counter advances, `row_addr` shows the refreshed row, and `dout` and `dout_oe` keep their values.
- R11: `seq_err` pulses for one clock for any of three cases: row and column strobes falling in the same sample, a column fall during a refresh cycle, or a `we_n` fall while the row strobe is high and the column strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Data pins driven (0 means high impedance) |
| cyc_class | output | 3 | Current cycle class code |
| row_addr | output | ADDR_W | Latched or refreshed row |
| col_addr | output | ADDR_W | Latched column |
| rfsh_row_ctr | output | ADDR_W | Internal refresh row counter |
| seq_err | output | 1 | Illegal strobe order pulse |

## Verification
A wrong refresh-counter value shows at `row_addr` on the very next counter-driven refresh, one clock after the row strobe falls. It also shows on `rfsh_row_ctr` at once. A stale read or hidden-refresh flag shows as a wrong `cyc_class`, or as `dout_oe` dropping or rising, one clock after the next strobe edge. A corrupt array word only appears when that word is read back, so the bench reads back every word it writes.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

    // Positions of the strobes inside the sampled strobe vector
    localparam int SB_RAS = 0;
    localparam int SB_CAS = 1;
    localparam int SB_WE  = 2;
    localparam int SB_OE  = 3;
    localparam int SB_NUM = 4;

    typedef enum logic [2:0] {
        CYC_STANDBY  = 3'd0,
        CYC_READ     = 3'd1,
        CYC_WRITE    = 3'd2,
        CYC_RMW      = 3'd3,
        CYC_PAGE     = 3'd4,
        CYC_HIDDEN   = 3'd5,
        CYC_RAS_ONLY = 3'd6,
        CYC_CBR      = 3'd7
    } cyc_class_e;

    // A column access after the first one in an open row is a page access
    function automatic cyc_class_e pick_class(input logic paged, input cyc_class_e base);
        return paged ? CYC_PAGE : base;
    endfunction

endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl_n;
    end

    assign fall = prev_q & ~lvl_n;
    assign rise = ~prev_q & lvl_n;
endmodule

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dram_cell_store.sv
module dram_cell_store #(
    parameter int DW = 4,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 4,
    parameter int ROW_IDX_W = 3,
    parameter int COL_IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic [2:0]        cyc_class,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [ADDR_W-1:0] rfsh_row_ctr,
    output logic              seq_err
);
    localparam int IDX_W = ROW_IDX_W + COL_IDX_W;

    logic [SB_NUM-1:0] fall, rise;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_fall, oe_rise;
    logic unused_we_rise;

    dram_strobe_edges #(.N(SB_NUM)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .lvl_n ({oe_n, we_n, cas_n, ras_n}),
        .fall  (fall),
        .rise  (rise)
    );

    assign ras_fall       = fall[SB_RAS];
    assign ras_rise       = rise[SB_RAS];
    assign cas_fall       = fall[SB_CAS];
    assign cas_rise       = rise[SB_CAS];
    assign we_fall        = fall[SB_WE];
    assign oe_fall        = fall[SB_OE];
    assign oe_rise        = rise[SB_OE];
    assign unused_we_rise = rise[SB_WE];

    // Cycle state
    cyc_class_e        cls_q;
    logic [ADDR_W-1:0] row_q, col_q;
    logic [DATA_W-1:0] dout_q;
    logic              dout_oe_q, seq_err_q;
    logic              row_open, rfsh_cyc, col_seen, paged;
    logic              rd_done, wr_done, hid_arm;

    // Event decode
    logic cas_acc, early_wr, early_rd, late_ok, late_rd, late_wr, rfsh_step;

    assign rfsh_step = ras_fall && !cas_fall && !cas_n;
    assign cas_acc   = cas_fall && !ras_fall && !ras_n && !rfsh_cyc && row_open;
    assign early_wr  = cas_acc && !we_n;
    assign early_rd  = cas_acc && we_n && !oe_n;
    assign late_ok   = row_open && !ras_n && !cas_n && col_seen && !cas_fall;
    assign late_rd   = late_ok && oe_fall && we_n && !rd_done;
    assign late_wr   = late_ok && we_fall && !wr_done;

    // Refresh row counter
    logic [ADDR_W-1:0] ctr;

    dram_rfsh_ctr #(.W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .step (rfsh_step),
        .cnt  (ctr)
    );

    // Storage array
    logic [ADDR_W-1:0] acc_col;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_data;

    assign acc_col = cas_acc ? addr : col_q;
    assign wr_idx  = {row_q[ROW_IDX_W-1:0], acc_col[COL_IDX_W-1:0]};
    assign rd_idx  = wr_idx;

    dram_cell_store #(.DW(DATA_W), .IW(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (early_wr || late_wr),
        .wr_idx  (wr_idx),
        .wr_data (din),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q     <= CYC_STANDBY;
            row_q     <= '0;
            col_q     <= '0;
            dout_q    <= '0;
            dout_oe_q <= 1'b0;
            seq_err_q <= 1'b0;
            row_open  <= 1'b0;
            rfsh_cyc  <= 1'b0;
            col_seen  <= 1'b0;
            paged     <= 1'b0;
            rd_done   <= 1'b0;
            wr_done   <= 1'b0;
            hid_arm   <= 1'b0;
        end else begin
            seq_err_q <= 1'b0;
            if (ras_fall && cas_fall) begin
                seq_err_q <= 1'b1;
            end else if (ras_fall) begin
                if (!cas_n) begin
                    rfsh_cyc <= 1'b1;
                    row_q    <= ctr;
                    if (hid_arm) begin
                        cls_q <= CYC_HIDDEN;
                    end else begin
                        cls_q     <= CYC_CBR;
                        dout_oe_q <= 1'b0;
                    end
                end else begin
                    row_open <= 1'b1;
                    row_q    <= addr;
                    cls_q    <= CYC_RAS_ONLY;
                    col_seen <= 1'b0;
                    paged    <= 1'b0;
                    rd_done  <= 1'b0;
                    wr_done  <= 1'b0;
                    hid_arm  <= 1'b0;
                end
            end else if (ras_rise) begin
                row_open <= 1'b0;
                rfsh_cyc <= 1'b0;
                if (cas_n) begin
                    cls_q     <= CYC_STANDBY;
                    dout_oe_q <= 1'b0;
                    rd_done   <= 1'b0;
                    hid_arm   <= 1'b0;
                end else begin
                    hid_arm <= rd_done;
                end
            end else if (cas_fall) begin
                if (!ras_n && rfsh_cyc) begin
                    seq_err_q <= 1'b1;
                end else if (cas_acc) begin
                    col_q    <= addr;
                    col_seen <= 1'b1;
                    paged    <= col_seen;
                    rd_done  <= early_rd;
                    wr_done  <= early_wr;
                    if (early_wr) begin
                        dout_oe_q <= 1'b0;
                        cls_q     <= pick_class(col_seen, CYC_WRITE);
                    end else if (early_rd) begin
                        dout_q    <= rd_data;
                        dout_oe_q <= 1'b1;
                        cls_q     <= pick_class(col_seen, CYC_READ);
                    end
                end
            end else if (cas_rise && ras_n) begin
                cls_q     <= CYC_STANDBY;
                dout_oe_q <= 1'b0;
                rd_done   <= 1'b0;
                hid_arm   <= 1'b0;
            end

            if (late_rd) begin
                dout_q    <= rd_data;
                dout_oe_q <= 1'b1;
                rd_done   <= 1'b1;
                cls_q     <= pick_class(paged, CYC_READ);
            end
            if (we_fall && ras_n && !cas_n) begin
                seq_err_q <= 1'b1;
            end else if (late_wr) begin
                wr_done <= 1'b1;
                cls_q   <= rd_done ? CYC_RMW : pick_class(paged, CYC_WRITE);
            end
            if (oe_rise) dout_oe_q <= 1'b0;
        end
    end

    assign dout         = dout_q;
    assign dout_oe      = dout_oe_q;
    assign cyc_class    = cls_q;
    assign row_addr     = row_q;
    assign col_addr     = col_q;
    assign rfsh_row_ctr = ctr;
    assign seq_err      = seq_err_q;

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n) |=> !dout_oe); // R4
    AST_CBR_HIZ: assert property (@(posedge clk) disable iff (rst)
        (rfsh_step && !hid_arm) |=> !dout_oe); // R3
    AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rfsh_step && hid_arm && !oe_rise) |=> ($stable(dout_oe) && $stable(dout))); // R10
    AST_CTR_MOVE: assert property (@(posedge clk) disable iff (rst)
        rfsh_step |=> (rfsh_row_ctr != $past(rfsh_row_ctr))); // R6
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rfsh_step |=> $stable(rfsh_row_ctr)); // R6
    AST_EDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cas_rise && !ras_n && !oe_rise) |=> ($stable(dout_oe) && $stable(dout))); // R9
    AST_EARLY_WR_HIZ: assert property (@(posedge clk) disable iff (rst)
        early_wr |=> !dout_oe); // R7
    AST_SIMUL_FALL_ERR: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && cas_fall) |=> seq_err); // R11
endmodule

// File: tb/dram_cycle_decoder_test.sv
`timescale 1ns/1ps
module dram_cycle_decoder_test;
    localparam int AW = 11;
    localparam int DW = 4;
    localparam int F_OE = 0, F_DOUT = 1, F_CLS = 2, F_ROW = 3, F_COL = 4, F_CTR = 5, F_ERR = 6;

    typedef struct {
        int    fld;
        int    val;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe, seq_err;
    logic [2:0] cyc_class;
    logic [AW-1:0] row_addr, col_addr, rfsh_row_ctr;

    always #2.5 clk = ~clk;

    dram_cycle_decoder uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .cyc_class(cyc_class),
        .row_addr(row_addr), .col_addr(col_addr), .rfsh_row_ctr(rfsh_row_ctr), .seq_err(seq_err)
    );

    item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int ctr_m = 0;
    bit finished = 1'b0;
    logic [DW-1:0] mem_m [64];

    function automatic int idx(input int r, input int c);
        return ((r & 7) << 3) | (c & 7);
    endfunction

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input int a, input int d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        addr = AW'(a); din = DW'(d);
    endtask

    task automatic expect_v(input int fld, input int val, input string req);
        item_t it;
        it.fld = fld; it.val = val; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor: compares queued expectations just after the active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                int act;
                it = exp_q.pop_front();
                case (it.fld)
                    F_OE:    act = int'(dout_oe);
                    F_DOUT:  act = int'(dout);
                    F_CLS:   act = int'(cyc_class);
                    F_ROW:   act = int'(row_addr);
                    F_COL:   act = int'(col_addr);
                    F_CTR:   act = int'(rfsh_row_ctr);
                    default: act = int'(seq_err);
                endcase
                n_chk++;
                if (act != it.val) begin
                    n_fail++;
                    $display("FAIL %s field %0d: actual %0d expected %0d", it.req, it.fld, act, it.val);
                end
            end
        end
    end

    task automatic idle();
        drv(1, 1, 1, 1, 0, 0);
    endtask

    task automatic early_write(input int r, input int c, input int d);
        drv(0, 1, 1, 1, r, 0);
        expect_v(F_ROW, r, "R2"); expect_v(F_CLS, 6, "R2"); expect_v(F_OE, 0, "R2");
        drv(0, 0, 0, 1, c, d);
        mem_m[idx(r, c)] = DW'(d);
        expect_v(F_CLS, 2, "R7"); expect_v(F_COL, c, "R7"); expect_v(F_OE, 0, "R7");
        drv(0, 1, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
        expect_v(F_CLS, 0, "R4"); expect_v(F_OE, 0, "R4");
    endtask

    task automatic read_oe_first(input int r, input int c);
        drv(0, 1, 1, 0, r, 0);
        expect_v(F_CLS, 6, "R2"); expect_v(F_OE, 0, "R2");
        drv(0, 0, 1, 0, c, 0);
        expect_v(F_OE, 1, "R5"); expect_v(F_DOUT, int'(mem_m[idx(r, c)]), "R5"); expect_v(F_CLS, 1, "R5");
        drv(1, 1, 1, 1, 0, 0);
        expect_v(F_OE, 0, "R4"); expect_v(F_CLS, 0, "R4");
    endtask

    task automatic cbr(input bit chk);
        drv(1, 0, 1, 1, 'h3AA, 0);
        drv(0, 0, 1, 1, 'h155, 0);
        if (chk) begin
            expect_v(F_CLS, 7, "R3"); expect_v(F_ROW, ctr_m, "R3");
            expect_v(F_CTR, (ctr_m + 1) % 2048, "R6"); expect_v(F_OE, 0, "R3");
        end
        ctr_m = (ctr_m + 1) % 2048;
        drv(1, 0, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle();
        expect_v(F_OE, 0, "R1"); expect_v(F_CLS, 0, "R1");
        expect_v(F_CTR, 0, "R1"); expect_v(F_ERR, 0, "R1");

        early_write(5, 2, 'hA);
        early_write(5, 3, 'h5);
        early_write(9, 2, 'hC);

        // Read started by late OE, then page access and EDO hold
        drv(0, 1, 1, 1, 5, 0);
        expect_v(F_CLS, 6, "R2");
        drv(0, 0, 1, 1, 2, 0);
        expect_v(F_OE, 0, "R5");
        drv(0, 0, 1, 0, 0, 0);
        expect_v(F_OE, 1, "R5"); expect_v(F_DOUT, 'hA, "R5"); expect_v(F_CLS, 1, "R5");
        drv(0, 1, 1, 0, 0, 0);
        expect_v(F_OE, 1, "R9"); expect_v(F_DOUT, 'hA, "R9");
        drv(0, 0, 1, 0, 3, 0);
        expect_v(F_CLS, 4, "R8"); expect_v(F_COL, 3, "R8");
        expect_v(F_DOUT, 'h5, "R8"); expect_v(F_OE, 1, "R8");
        drv(0, 0, 1, 1, 0, 0);
        expect_v(F_OE, 0, "R9");
        idle();
        expect_v(F_CLS, 0, "R4");

        read_oe_first(9, 2);

        // Row-only refresh
        drv(0, 1, 1, 1, 'h7FF, 0);
        expect_v(F_ROW, 'h7FF, "R2"); expect_v(F_CLS, 6, "R2");
        expect_v(F_OE, 0, "R2"); expect_v(F_CTR, 0, "R2");
        idle();
        expect_v(F_CLS, 0, "R4"); expect_v(F_CTR, 0, "R6");

        cbr(1'b1);
        cbr(1'b1);

        // Hidden refresh keeps the read data on the pins
        drv(0, 1, 1, 0, 5, 0);
        drv(0, 0, 1, 0, 3, 0);
        expect_v(F_OE, 1, "R5"); expect_v(F_DOUT, 'h5, "R5");
        drv(1, 0, 1, 0, 0, 0);
        expect_v(F_OE, 1, "R10"); expect_v(F_DOUT, 'h5, "R10");
        drv(0, 0, 1, 0, 'h55, 0);
        expect_v(F_CLS, 5, "R10"); expect_v(F_ROW, ctr_m, "R10");
        expect_v(F_CTR, ctr_m + 1, "R10"); expect_v(F_OE, 1, "R10"); expect_v(F_DOUT, 'h5, "R10");
        ctr_m = ctr_m + 1;
        drv(1, 0, 1, 0, 0, 0);
        idle();
        expect_v(F_OE, 0, "R4"); expect_v(F_CLS, 0, "R4");

        // Read-modify-write
        drv(0, 1, 1, 0, 9, 0);
        drv(0, 0, 1, 0, 2, 0);
        expect_v(F_DOUT, 'hC, "R5");
        drv(0, 0, 1, 1, 0, 0);
        expect_v(F_OE, 0, "R9");
        drv(0, 0, 0, 1, 0, 6);
        mem_m[idx(9, 2)] = 4'h6;
        expect_v(F_CLS, 3, "R7");
        drv(0, 1, 1, 1, 0, 0);
        idle();
        read_oe_first(9, 2);
        read_oe_first(5, 2);

        // Illegal strobe orders
        drv(0, 0, 1, 1, 0, 0);
        expect_v(F_ERR, 1, "R11"); expect_v(F_CTR, ctr_m, "R6");
        idle();
        expect_v(F_ERR, 0, "R11"); expect_v(F_CLS, 0, "R4");
        drv(1, 0, 1, 1, 0, 0);
        drv(0, 0, 1, 1, 0, 0);
        expect_v(F_CLS, 7, "R3");
        ctr_m = ctr_m + 1;
        drv(0, 1, 1, 1, 0, 0);
        expect_v(F_ERR, 0, "R11");
        drv(0, 0, 1, 1, 0, 0);
        expect_v(F_ERR, 1, "R11");
        drv(1, 0, 1, 1, 0, 0);
        idle();
        drv(1, 0, 1, 1, 0, 0);
        drv(1, 0, 0, 1, 0, 0);
        expect_v(F_ERR, 1, "R11");
        idle();
        expect_v(F_ERR, 0, "R11"); expect_v(F_CTR, ctr_m, "R6");

        // Counter wrap
        while (ctr_m != 2047) cbr(1'b0);
        idle();
        expect_v(F_CTR, 2047, "R6");
        cbr(1'b1);
        idle();
        expect_v(F_CTR, 0, "R6");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule